// File: doc/BRIEF.md
# SDRAM Initialization Command Port

This block is a bus slave on a DDR SDRAM controller. It is used only while the memory is being brought up. From reset the port is in configuration mode. In this mode, each bus write that lands in the memory window becomes one raw SDRAM command on the device pins. The write address carries the whole command:

- The row field is driven onto the address lines.
- The bank field is driven onto the bank pins.
- A three-bit field is driven onto the RAS#, CAS# and WE# strobes.

The write data is never used. Software walks through the power-up sequence with ordinary stores: NOP with clock enable, precharge-all, mode register loads and auto refreshes.

The first bus read inside the window ends configuration mode. That read returns zero, and the port raises the enable that hands the memory to the normal controller. From then until the next reset the port ignores all bus traffic and holds the command pins at NOP.

Top module: `sdram_cfg_port`

## Requirements
- R1: After reset the port is in configuration mode with `ddr_en` low, `sd_cke` low, `sd_cs_n` high, `sd_ras_n`/`sd_cas_n`/`sd_we_n` all high, `sd_addr` and `sd_ba` zero and `bus_ready` low.
- R2: A write accepted in the window in configuration mode drives `sd_cs_n` low for exactly one clock, starting the cycle after acceptance. In that clock `{sd_ras_n,sd_cas_n,sd_we_n}` equals address bits [6:4], with bit 6 on RAS#. Any 3-bit code passes through; 111 is NOP, 010 precharge, 001 auto refresh and 000 load mode register.
- R3: During the command clock `sd_addr` equals bus address bits [25:13], so address bit 23 reaches line A10 (precharge all). In every other cycle `sd_addr` is zero.
- R4: During the command clock `sd_ba` equals bus address bits [12:11]. In every other cycle it is zero.
- R5: Whenever `sd_cs_n` is high, the three strobes are all high (NOP encoding).
- R6: For a configuration write, `bus_ready` is high for exactly one cycle, the cycle after the command clock. The write data has no effect on any output.
- R7: `sd_cke` stays low from reset until the first configuration command and is high during that command's clock. Once high it stays high until reset.
- R8: The window is the set of addresses whose bits [31:28] equal 4'h1. An access outside it produces no command, no `bus_ready` and no change of mode.
- R9: A read in the window in configuration mode gets `bus_ready` in the next cycle with `bus_rdata` zero. In that same cycle `cfg_mode` falls and `ddr_en` rises.
- R10: Once `ddr_en` is high, no access produces a command or `bus_ready`, and `cfg_mode` stays low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request, held until `bus_ready` |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address; carries the command fields |
| bus_wdata | input | 32 | Write data (unused) |
| bus_ready | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, always zero |
| cfg_mode | output | 1 | High while raw-command mode is active |
| ddr_en | output | 1 | High once normal operation is enabled |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_addr | output | 13 | SDRAM address lines |
| sd_ba | output | 2 | SDRAM bank address |

## Verification
The hardest case to reach is the one-way switch of mode. Only one read ever takes effect, and every later access must then be dead at the pins. After that point the bench can reach configuration behaviour again only through a second reset.

The stimulus works in this order:
1. It first proves that out-of-window reads do not trip the switch.
2. It then sweeps every command code, every bank and several row patterns. The unused address bits and the write data are set to junk during the sweep.
3. Only then does it issue the single enabling read.
4. It follows with both writes and reads and expects silence from each.
5. Finally it resets again and confirms the initial state comes back.

// File: rtl/sdcfg_pkg.sv
package sdcfg_pkg;

  // Raw command codes on {RAS#, CAS#, WE#}
  localparam logic [2:0] CMD_LMR = 3'b000;
  localparam logic [2:0] CMD_REF = 3'b001;
  localparam logic [2:0] CMD_PRE = 3'b010;
  localparam logic [2:0] CMD_NOP = 3'b111;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_ACK   = 2'd2
  } port_state_t;

  function automatic logic is_nop(input logic [2:0] code);
    return code == CMD_NOP;
  endfunction

endpackage

// File: rtl/sdcfg_field_decode.sv
module sdcfg_field_decode #(
  parameter int ADDR_W  = 32,
  parameter int ROW_W   = 13,
  parameter int ROW_LSB = 13,
  parameter int BA_W    = 2,
  parameter int BA_LSB  = 11,
  parameter int CMD_LSB = 4,
  parameter int TAG_W   = 4,
  parameter logic [TAG_W-1:0] WIN_TAG = 4'h1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ROW_W-1:0]  row,
  output logic [BA_W-1:0]   bank,
  output logic [2:0]        code,
  output logic              win_hit
);

  localparam int TAG_LSB = ADDR_W - TAG_W;

  function automatic logic [ROW_W-1:0] take_row(input logic [ADDR_W-1:0] a);
    return a[ROW_LSB +: ROW_W];
  endfunction

  function automatic logic [BA_W-1:0] take_bank(input logic [ADDR_W-1:0] a);
    return a[BA_LSB +: BA_W];
  endfunction

  function automatic logic [2:0] take_code(input logic [ADDR_W-1:0] a);
    return a[CMD_LSB +: 3];
  endfunction

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return a[TAG_LSB +: TAG_W] == WIN_TAG;
  endfunction

  always_comb begin
    row     = take_row(addr);
    bank    = take_bank(addr);
    code    = take_code(addr);
    win_hit = in_window(addr);
  end

  initial begin
    assert (ROW_LSB + ROW_W <= TAG_LSB) else $error("row field overlaps window tag");
    assert (CMD_LSB + 3 <= BA_LSB) else $error("command field overlaps bank field");
    assert (BA_LSB + BA_W <= ROW_LSB) else $error("bank field overlaps row field");
  end

endmodule

// File: rtl/sdcfg_seq.sv
module sdcfg_seq
  import sdcfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_valid,
  input  logic bus_write,
  input  logic win_hit,
  output logic issue_evt,
  output logic enable_evt,
  output logic bus_ready,
  output logic cfg_mode,
  output logic ddr_en
);

  port_state_t st_q;
  port_state_t st_d;
  logic        accept;

  // Only an idle port still in configuration mode takes a request
  assign accept     = (st_q == ST_IDLE) && cfg_mode && bus_valid && win_hit;
  assign issue_evt  = accept && bus_write;
  assign enable_evt = accept && !bus_write;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (issue_evt)       st_d = ST_ISSUE;
        else if (enable_evt) st_d = ST_ACK;
      end
      ST_ISSUE: st_d = ST_ACK;
      ST_ACK:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      bus_ready <= 1'b0;
      cfg_mode  <= 1'b1;
      ddr_en    <= 1'b0;
    end else begin
      st_q      <= st_d;
      bus_ready <= (st_q == ST_ISSUE) || enable_evt;
      if (enable_evt) begin
        cfg_mode <= 1'b0;
        ddr_en   <= 1'b1;
      end
    end
  end

  a_r6_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);
  a_r6_ack_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    issue_evt |=> ##1 bus_ready);
  a_r9_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
    enable_evt |=> (bus_ready && ddr_en && !cfg_mode));
  a_r10_no_reenter: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> !cfg_mode);
  a_r10_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ddr_en && !bus_ready) |=> !bus_ready);
  a_r8_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !win_hit) |=> !bus_ready);

endmodule

// File: rtl/sdcfg_pins.sv
module sdcfg_pins
  import sdcfg_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_evt,
  input  logic             enable_evt,
  input  logic [ROW_W-1:0] row,
  input  logic [BA_W-1:0]  bank,
  input  logic [2:0]       code,
  output logic             sd_cke,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [ROW_W-1:0] sd_addr,
  output logic [BA_W-1:0]  sd_ba
);

  logic [2:0] strobe_q;
  logic       cmd_is_nop;

  assign cmd_is_nop = is_nop(code);
  assign {sd_ras_n, sd_cas_n, sd_we_n} = strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_cke   <= 1'b0;
      sd_cs_n  <= 1'b1;
      strobe_q <= CMD_NOP;
      sd_addr  <= '0;
      sd_ba    <= '0;
    end else begin
      if (issue_evt) begin
        sd_cs_n  <= 1'b0;
        strobe_q <= code;
        sd_addr  <= row;
        sd_ba    <= bank;
      end else begin
        sd_cs_n  <= 1'b1;
        strobe_q <= CMD_NOP;
        sd_addr  <= '0;
        sd_ba    <= '0;
      end
      // Any command (normally a NOP first) or the enable wakes the clock
      if ((issue_evt && (cmd_is_nop || !sd_cke)) || enable_evt)
        sd_cke <= 1'b1;
    end
  end

  a_r2_cs_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |=> sd_cs_n);
  a_r2_cmd_follows: assert property (@(posedge clk) disable iff (!rst_n)
    issue_evt |=> !sd_cs_n);
  a_r5_nop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cs_n |-> (sd_ras_n && sd_cas_n && sd_we_n));
  a_r3_addr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cs_n |-> (sd_addr == '0 && sd_ba == '0));
  a_r7_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke |=> sd_cke);
  a_r7_cke_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |-> sd_cke);

endmodule

// File: rtl/sdram_cfg_port.sv
module sdram_cfg_port
  import sdcfg_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int ROW_W   = 13,
  parameter int ROW_LSB = 13,
  parameter int BA_W    = 2,
  parameter int BA_LSB  = 11,
  parameter int CMD_LSB = 4,
  parameter int TAG_W   = 4,
  parameter logic [TAG_W-1:0] WIN_TAG = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cfg_mode,
  output logic              ddr_en,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [BA_W-1:0]   sd_ba
);

  logic [ROW_W-1:0] dec_row;
  logic [BA_W-1:0]  dec_bank;
  logic [2:0]       dec_code;
  logic             win_hit;
  logic             issue_evt;
  logic             enable_evt;
  logic             unused_data;

  // Write data never reaches the pins
  assign unused_data = ^bus_wdata;
  assign bus_rdata   = '0;

  sdcfg_field_decode #(
    .ADDR_W (ADDR_W), .ROW_W (ROW_W), .ROW_LSB (ROW_LSB),
    .BA_W (BA_W), .BA_LSB (BA_LSB), .CMD_LSB (CMD_LSB),
    .TAG_W (TAG_W), .WIN_TAG (WIN_TAG)
  ) u_decode (
    .addr    (bus_addr),
    .row     (dec_row),
    .bank    (dec_bank),
    .code    (dec_code),
    .win_hit (win_hit)
  );

  sdcfg_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .win_hit    (win_hit),
    .issue_evt  (issue_evt),
    .enable_evt (enable_evt),
    .bus_ready  (bus_ready),
    .cfg_mode   (cfg_mode),
    .ddr_en     (ddr_en)
  );

  sdcfg_pins #(.ROW_W (ROW_W), .BA_W (BA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_evt  (issue_evt),
    .enable_evt (enable_evt),
    .row        (dec_row),
    .bank       (dec_bank),
    .code       (dec_code),
    .sd_cke     (sd_cke),
    .sd_cs_n    (sd_cs_n),
    .sd_ras_n   (sd_ras_n),
    .sd_cas_n   (sd_cas_n),
    .sd_we_n    (sd_we_n),
    .sd_addr    (sd_addr),
    .sd_ba      (sd_ba)
  );

  a_r9_mode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode != ddr_en);
  a_r10_no_cmd_after_en: assert property (@(posedge clk) disable iff (!rst_n)
    (ddr_en && sd_cs_n) |=> sd_cs_n);

endmodule

// File: tb/test_sdram_cfg_port.sv
`timescale 1ns/1ps
module test_sdram_cfg_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        cfg_mode, ddr_en, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [12:0] sd_addr;
  logic [1:0]  sd_ba;

  int vectors = 0;
  int misses  = 0;

  always #2.5 clk = ~clk;

  sdram_cfg_port i_sdram_cfg_port (
    .clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_wdata,
    .bus_ready, .bus_rdata, .cfg_mode, .ddr_en, .sd_cke, .sd_cs_n,
    .sd_ras_n, .sd_cas_n, .sd_we_n, .sd_addr, .sd_ba
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  function automatic logic [31:0] pins_idle_word();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr};
  endfunction

  localparam logic [31:0] IDLE_WORD = {1'b1, 3'b111, 2'b00, 13'h0};

  task automatic check_reset_state;
    chk("R1 cfg_mode", cfg_mode, 1);
    chk("R1 ddr_en", ddr_en, 0);
    chk("R1 cke", sd_cke, 0);
    chk("R1 pins", pins_idle_word(), IDLE_WORD);
    chk("R1 ready", bus_ready, 0);
  endtask

  // Full handshake for one configuration write
  task automatic cfg_write(input logic [31:0] a, input logic [31:0] d);
    logic [12:0] erow;
    logic [1:0]  eba;
    logic [2:0]  ecode;
    erow  = 13'((a >> 13) % 8192);
    eba   = 2'((a >> 11) % 4);
    ecode = 3'((a >> 4) % 8);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    chk("R2 cs low", sd_cs_n, 0);
    chk("R2 strobes", {sd_ras_n, sd_cas_n, sd_we_n}, ecode);
    chk("R3 row", sd_addr, erow);
    chk("R3 A10", sd_addr[10], (a >> 23) % 2);
    chk("R4 bank", sd_ba, eba);
    chk("R6 no early ready", bus_ready, 0);
    chk("R7 cke with cmd", sd_cke, 1);
    @(posedge clk); #1;
    chk("R6 ready", bus_ready, 1);
    chk("R5 nop after cmd", pins_idle_word(), IDLE_WORD);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    @(posedge clk); #1;
    chk("R6 ready single", bus_ready, 0);
    chk("R2 single clock", sd_cs_n, 1);
  endtask

  // Access expected to be ignored: no command, no ready, no mode change
  task automatic dead_access(input logic wr, input logic [31:0] a, input logic exp_mode, input string req);
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_addr = a; bus_wdata = 32'hDEAD_BEEF;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      chk({req, " no cmd"}, pins_idle_word(), IDLE_WORD);
      chk({req, " no ready"}, bus_ready, 0);
      chk({req, " mode"}, cfg_mode, exp_mode);
    end
    @(negedge clk);
    bus_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired (all requirements)");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_reset_state();
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 cke low before first cmd", sd_cke, 0);
    chk("R1 mode held", cfg_mode, 1);

    // R8: misses outside the window, both kinds
    dead_access(1, 32'h2000_0070, 1, "R8 write miss");
    dead_access(0, 32'h0000_0000, 1, "R8 read miss");
    chk("R8 cke unchanged", sd_cke, 0);

    // R7: first command is NOP, CKE rises with it
    cfg_write(32'h1000_0070, 32'h1234_5678);
    // Precharge all: A10 via address bit 23
    cfg_write(32'h1080_0020, 32'h0);

    // Sweep codes, banks and row patterns with junk in unused bits (R6)
    for (int c = 0; c < 8; c++)
      for (int b = 0; b < 4; b++)
        for (int r = 0; r < 4; r++) begin
          logic [12:0] rowv;
          logic [31:0] av;
          case (r)
            0: rowv = 13'h0000;
            1: rowv = 13'h0400;
            2: rowv = 13'h1FFF;
            default: rowv = 13'(13'h0A5 + c * 37 + b * 11);
          endcase
          av = 32'h1000_0000 + (32'(r) << 26) + (32'(rowv) << 13)
             + (32'(b) << 11) + (32'((c + b) % 16) << 7)
             + (32'(c) << 4) + 32'((r * 5 + c) % 16);
          cfg_write(av, 32'(c * 1000 + b * 10 + r));
        end

    // R9: the enabling read
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = 32'h1ABC_0000;
    @(posedge clk); #1;
    chk("R9 ready", bus_ready, 1);
    chk("R9 rdata zero", bus_rdata, 0);
    chk("R9 cfg_mode low", cfg_mode, 0);
    chk("R9 ddr_en high", ddr_en, 1);
    chk("R9 no cmd", pins_idle_word(), IDLE_WORD);
    @(negedge clk);
    bus_valid = 0;

    // R10: everything after enable is ignored
    dead_access(1, 32'h1000_0070, 0, "R10 write");
    dead_access(1, 32'h1080_0020, 0, "R10 write");
    dead_access(0, 32'h1000_0000, 0, "R10 read");
    chk("R10 en held", ddr_en, 1);
    chk("R7 cke stays high", sd_cke, 1);

    // R1 again after a second reset
    @(negedge clk) rst_n = 0;
    @(posedge clk); #1;
    check_reset_state();
    summary();
  end

endmodule